// File: doc/BRIEF.md
# ADC Test-Pattern Generator and Output Formatter

This block sits at the digital back end of a 16-bit pipelined converter, between the raw conversion result and the output pad drivers. On every sample clock it accepts one offset-binary sample. It can swap that sample for a generated test word, adds a signed digital trim offset with saturation, and can complement the word. It then encodes the result as offset binary, two's complement or Gray code before registering it onto the output bus.

The generated words cover three static levels (midscale and the two full-scale codes) and two words that alternate every clock: a checkerboard, and all ones against all zeros. There are also two pseudo-random sequences, one short and one long, each with its own hold-in-seed control. Test words pass through the same offset, invert and encode path as live data, so the whole output chain can be exercised from a pattern. All configuration arrives as static, register-style inputs that are sampled together with the data word, so a change takes effect on a sample boundary.

Top module: `adc_pattern_fmt`

## Requirements
- R1: The output is registered with a latency of exactly two clocks from the sample and configuration inputs to `data_o`. While `rst_n` is low, `data_o` is 0x0000.
- R2: The trim offset is an 8-bit two's-complement value from -128 to +127 LSB. It is added to the offset-binary word, and the sum saturates to 0x0000 below zero and to 0xFFFF above full scale instead of wrapping.
- R3: When `invert_i` is 1, the offset-binary word is bitwise complemented after the offset is added and before it is encoded.
- R4: `format_i` selects the encoding of the offset-binary word b. 00 passes b unchanged, 01 gives two's complement (b with its MSB flipped), 10 gives Gray code b XOR (b >> 1), and 11 behaves like 00.
- R5: When `out_disable_i` is 1, the output word is 0x0000 regardless of every other input.
- R6: `test_mode_i` 0000 passes the live sample, and so does every code from 1000 to 1111. Code 0001 drives 0x8000, 0010 drives 0xFFFF and 0011 drives 0x0000, all as offset-binary words.
- R7: `test_mode_i` 0100 drives a checkerboard that alternates between 0x5555 and 0xAAAA on every clock.
- R8: `test_mode_i` 0111 drives a word that alternates between 0xFFFF and 0x0000 on every clock.
- R9: `test_mode_i` 0110 drives the short sequence. It is a 9-bit register s, seeded to all ones, that steps 16 times per clock. Each step computes f = s[8] XOR s[4], shifts s left and inserts f at bit 0. The 16 values of f fill the word from MSB to LSB. While `pn_short_hold_i` is 1, s is held at its seed.
- R10: `test_mode_i` 0101 drives the long sequence, built in the same way from a 23-bit register with f = s[22] XOR s[17]. While `pn_long_hold_i` is 1, that register is held at all ones.
- R11: Test words pass through the offset, invert and format stages exactly as live samples do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 16 | Offset-binary conversion result |
| test_mode_i | input | 4 | Test-word select |
| pn_long_hold_i | input | 1 | Holds the long sequence in its seed |
| pn_short_hold_i | input | 1 | Holds the short sequence in its seed |
| offset_i | input | 8 | Signed trim offset in LSB |
| invert_i | input | 1 | Complements the data word |
| format_i | input | 2 | Output encoding select |
| out_disable_i | input | 1 | Forces the output word to idle |
| data_o | output | 16 | Formatted output word |

## Verification
The live path is driven with a stepped sweep of samples under every encoding, both invert settings and a set of offsets. Those runs separate the three encoders from each other and show where invert sits relative to the offset. Samples at and next to both code limits are then combined with all 256 offsets, which shows saturation apart from wraparound in both directions. Static test words are checked with nonzero offsets and with invert, which proves they share the live path. The alternating words are checked for their value set and for a change on every clock. Each sequence is compared word by word against an arithmetic model after its seed hold is released, and the hold itself is checked by watching the output stay fixed.

// File: rtl/adcpf_pkg.sv
package adcpf_pkg;

   typedef enum logic [3:0] {
      TM_LIVE   = 4'd0,
      TM_MID    = 4'd1,
      TM_POSFS  = 4'd2,
      TM_NEGFS  = 4'd3,
      TM_CHECK  = 4'd4,
      TM_PNLONG = 4'd5,
      TM_PNSHRT = 4'd6,
      TM_FLIP   = 4'd7
   } tmode_e;

   typedef enum logic [1:0] {
      FMT_OBIN = 2'd0,
      FMT_TWOS = 2'd1,
      FMT_GRAY = 2'd2,
      FMT_RSVD = 2'd3
   } ofmt_e;

endpackage

// File: rtl/adcpf_pn_gen.sv
module adcpf_pn_gen #(
   parameter int LEN = 9,
   parameter int TAP = 5,
   parameter int DW  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_i,
   output logic [DW-1:0] word_o
);

   localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

   generate
      if (LEN < 3 || TAP < 1 || TAP >= LEN) begin : g_bad_poly
         $error("adcpf_pn_gen: tap must lie strictly inside the register");
      end
   endgenerate

   logic [LEN-1:0] state_q;
   logic [LEN-1:0] state_nxt;

   always_comb begin
      logic [LEN-1:0] s;
      logic           fb;
      s      = state_q;
      word_o = '0;
      for (int i = DW - 1; i >= 0; i--) begin
         fb        = s[LEN-1] ^ s[TAP-1];
         word_o[i] = fb;
         s         = {s[LEN-2:0], fb};
      end
      state_nxt = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= SEED;
      else if (hold_i) state_q <= SEED;
      else             state_q <= state_nxt;
   end

   a_r9_r10_seed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (state_q == SEED));

   a_r9_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> (state_q != '0));

endmodule

// File: rtl/adcpf_offset_sat.sv
module adcpf_offset_sat #(
   parameter int DW = 16,
   parameter int OW = 8
) (
   input  logic [DW-1:0] word_i,
   input  logic [OW-1:0] offset_i,
   output logic [DW-1:0] word_o
);

   localparam int SW = DW + 2;

   generate
      if (OW >= DW) begin : g_bad_width
         $error("adcpf_offset_sat: offset must be narrower than the data");
      end
   endgenerate

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] top_code;

   always_comb begin
      top_code = $signed({2'b00, {DW{1'b1}}});
      sum      = $signed({2'b00, word_i})
               + $signed({{(SW-OW){offset_i[OW-1]}}, offset_i});
      if (sum < 0)             word_o = '0;
      else if (sum > top_code) word_o = '1;
      else                     word_o = sum[DW-1:0];
   end

endmodule

// File: rtl/adcpf_encode.sv
module adcpf_encode
   import adcpf_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] word_i,
   input  logic          invert_i,
   input  logic [1:0]    format_i,
   output logic [DW-1:0] word_o
);

   logic [DW-1:0] ob;
   logic [DW-1:0] gray;
   logic [DW-1:0] twos;

   assign ob   = invert_i ? ~word_i : word_i;
   assign twos = {~ob[DW-1], ob[DW-2:0]};

   genvar g;
   generate
      for (g = 0; g < DW - 1; g++) begin : g_gray
         assign gray[g] = ob[g] ^ ob[g+1];
      end
   endgenerate
   assign gray[DW-1] = ob[DW-1];

   always_comb begin
      case (ofmt_e'(format_i))
         FMT_TWOS: word_o = twos;
         FMT_GRAY: word_o = gray;
         default:  word_o = ob;
      endcase
   end

endmodule

// File: rtl/adc_pattern_fmt.sv
module adc_pattern_fmt
   import adcpf_pkg::*;
#(
   parameter int DW       = 16,
   parameter int OW       = 8,
   parameter int PNS_LEN  = 9,
   parameter int PNS_TAP  = 5,
   parameter int PNL_LEN  = 23,
   parameter int PNL_TAP  = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [15:0]   sample_i,
   input  logic [3:0]    test_mode_i,
   input  logic          pn_long_hold_i,
   input  logic          pn_short_hold_i,
   input  logic [7:0]    offset_i,
   input  logic          invert_i,
   input  logic [1:0]    format_i,
   input  logic          out_disable_i,
   output logic [15:0]   data_o
);

   localparam logic [DW-1:0] W_MID  = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] W_CHKA = {(DW/2){2'b01}};
   localparam logic [DW-1:0] W_CHKB = {(DW/2){2'b10}};

   generate
      if (DW != 16 || OW != 8) begin : g_bad_port
         $error("adc_pattern_fmt: port widths are fixed at 16 and 8");
      end
      if (DW % 2 != 0) begin : g_bad_even
         $error("adc_pattern_fmt: data width must be even");
      end
   endgenerate

   // pattern sources
   logic [DW-1:0] pn_short_w;
   logic [DW-1:0] pn_long_w;
   logic          alt_q;

   adcpf_pn_gen #(.LEN(PNS_LEN), .TAP(PNS_TAP), .DW(DW)) u_pn_short (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (pn_short_hold_i),
      .word_o (pn_short_w)
   );

   adcpf_pn_gen #(.LEN(PNL_LEN), .TAP(PNL_TAP), .DW(DW)) u_pn_long (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (pn_long_hold_i),
      .word_o (pn_long_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alt_q <= 1'b0;
      else        alt_q <= ~alt_q;
   end

   logic [DW-1:0] src_w;

   always_comb begin
      case (tmode_e'(test_mode_i))
         TM_MID:    src_w = W_MID;
         TM_POSFS:  src_w = '1;
         TM_NEGFS:  src_w = '0;
         TM_CHECK:  src_w = alt_q ? W_CHKB : W_CHKA;
         TM_PNLONG: src_w = pn_long_w;
         TM_PNSHRT: src_w = pn_short_w;
         TM_FLIP:   src_w = alt_q ? '0 : '1;
         default:   src_w = sample_i;
      endcase
   end

   // stage 1: trimmed word plus the configuration that travels with it
   logic [DW-1:0] trim_w;

   adcpf_offset_sat #(.DW(DW), .OW(OW)) u_trim (
      .word_i   (src_w),
      .offset_i (offset_i),
      .word_o   (trim_w)
   );

   logic [DW-1:0] s1_word;
   logic          s1_inv;
   logic [1:0]    s1_fmt;
   logic          s1_dis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_word <= '0;
         s1_inv  <= 1'b0;
         s1_fmt  <= 2'b00;
         s1_dis  <= 1'b1;
      end else begin
         s1_word <= trim_w;
         s1_inv  <= invert_i;
         s1_fmt  <= format_i;
         s1_dis  <= out_disable_i;
      end
   end

   // stage 2: encode and drive
   logic [DW-1:0] enc_w;

   adcpf_encode #(.DW(DW)) u_enc (
      .word_i   (s1_word),
      .invert_i (s1_inv),
      .format_i (s1_fmt),
      .word_o   (enc_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_o <= '0;
      else if (s1_dis) data_o <= '0;
      else             data_o <= enc_w;
   end

   a_r5_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      out_disable_i |=> ##1 (data_o == '0));

   a_r6_midscale: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode_i == 4'd1 && offset_i == 8'd0 && !invert_i &&
       format_i == 2'd0 && !out_disable_i) |=> ##1 (data_o == W_MID));

   a_r4_twos_midscale: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode_i == 4'd1 && offset_i == 8'd0 && !invert_i &&
       format_i == 2'd1 && !out_disable_i) |=> ##1 (data_o == '0));

   a_r2_posfs_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode_i == 4'd2 && !offset_i[7] && !invert_i &&
       format_i == 2'd0 && !out_disable_i) |=> ##1 (data_o == '1));

endmodule

// File: tb/adc_pattern_fmt_tb_top.sv
module adc_pattern_fmt_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sample_i = '0;
   logic [3:0]  test_mode_i = '0;
   logic        pn_long_hold_i = 1'b1;
   logic        pn_short_hold_i = 1'b1;
   logic [7:0]  offset_i = '0;
   logic        invert_i = 1'b0;
   logic [1:0]  format_i = '0;
   logic        out_disable_i = 1'b0;
   logic [15:0] data_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   adc_pattern_fmt dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .sample_i        (sample_i),
      .test_mode_i     (test_mode_i),
      .pn_long_hold_i  (pn_long_hold_i),
      .pn_short_hold_i (pn_short_hold_i),
      .offset_i        (offset_i),
      .invert_i        (invert_i),
      .format_i        (format_i),
      .out_disable_i   (out_disable_i),
      .data_o          (data_o)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1: run stalled, actual cycle %0d expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   // arithmetic model of the live/pattern path from the requirements
   function automatic logic [15:0] model(input logic [15:0] w, input logic [7:0] off,
                                         input logic inv, input logic [1:0] fmt,
                                         input logic dis);
      int sum;
      logic [15:0] b;
      if (dis) return 16'h0000;
      sum = int'(w) + int'($signed(off));
      if (sum < 0) b = 16'h0000;
      else if (sum > 65535) b = 16'hFFFF;
      else b = 16'(sum);
      if (inv) b = ~b;
      case (fmt)
         2'd1:    return b ^ 16'h8000;
         2'd2:    return b ^ (b >> 1);
         default: return b;
      endcase
   endfunction

   function automatic logic [47:0] pn_step(input int len, input int tap, input logic [31:0] st);
      logic [31:0] s;
      logic [15:0] w;
      logic        f;
      s = st;
      for (int i = 15; i >= 0; i--) begin
         f    = s[len-1] ^ s[tap-1];
         w[i] = f;
         s    = ((s << 1) | 32'(f)) & ((32'd1 << len) - 1);
      end
      return {s, w};
   endfunction

   // streaming pipeline of expected values (two-clock latency)
   logic [15:0] exp_q0, exp_q1;
   bit          val_q0 = 0, val_q1 = 0;
   string       tag_q0, tag_q1;

   task automatic step(input logic [15:0] smp, input logic [3:0] md, input logic [7:0] off,
                       input logic inv, input logic [1:0] fmt, input logic dis,
                       input string tag);
      logic [15:0] src;
      @(negedge clk);
      if (val_q1) chk(tag_q1, data_o, exp_q1);
      exp_q1 = exp_q0; val_q1 = val_q0; tag_q1 = tag_q0;
      sample_i = smp; test_mode_i = md; offset_i = off;
      invert_i = inv; format_i = fmt; out_disable_i = dis;
      case (md)
         4'd1:    src = 16'h8000;
         4'd2:    src = 16'hFFFF;
         4'd3:    src = 16'h0000;
         default: src = smp;
      endcase
      exp_q0 = model(src, off, inv, fmt, dis);
      val_q0 = 1; tag_q0 = tag;
   endtask

   task automatic flush();
      step(16'h0, 4'd0, 8'd0, 1'b0, 2'd0, 1'b0, "R1 flush");
      step(16'h0, 4'd0, 8'd0, 1'b0, 2'd0, 1'b0, "R1 flush");
      val_q0 = 0; val_q1 = 0;
   endtask

   task automatic alt_check(input logic [3:0] md, input logic [15:0] a, input logic [15:0] b,
                            input string tag);
      logic [15:0] prev;
      @(negedge clk);
      test_mode_i = md; offset_i = 8'd0; invert_i = 1'b0; format_i = 2'd0; out_disable_i = 1'b0;
      repeat (3) @(negedge clk);
      prev = data_o;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk({tag, " value set"}, data_o, (data_o == a) ? a : b);
         chk({tag, " flips"}, data_o, ~prev & ((prev == a) ? ~b : ~a) | ((prev == a) ? b : a) & ~(~prev & ((prev == a) ? ~b : ~a)));
         prev = data_o;
      end
   endtask

   task automatic pn_check(input logic [3:0] md, input int len, input int tap,
                           input bit long_sel, input string tag);
      logic [47:0] r;
      logic [31:0] st;
      @(negedge clk);
      test_mode_i = md; offset_i = 8'd0; invert_i = 1'b0; format_i = 2'd0; out_disable_i = 1'b0;
      pn_long_hold_i = 1'b1; pn_short_hold_i = 1'b1;
      repeat (3) @(negedge clk);
      st = (32'd1 << len) - 1;
      r  = pn_step(len, tap, st);
      for (int k = 0; k < 4; k++) begin
         chk({tag, " seed hold"}, data_o, r[15:0]);
         @(negedge clk);
      end
      if (long_sel) pn_long_hold_i = 1'b0; else pn_short_hold_i = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         r = pn_step(len, tap, st);
         chk({tag, " sequence"}, data_o, r[15:0]);
         st = r[47:16];
      end
      pn_long_hold_i = 1'b1; pn_short_hold_i = 1'b1;
   endtask

   initial begin
      logic [7:0] offs [6];
      logic [15:0] edges [6];
      offs[0] = 8'h00; offs[1] = 8'h01; offs[2] = 8'hFF;
      offs[3] = 8'h7F; offs[4] = 8'h80; offs[5] = 8'h05;
      edges[0] = 16'h0000; edges[1] = 16'h0001; edges[2] = 16'hFFFE;
      edges[3] = 16'hFFFF; edges[4] = 16'h007F; edges[5] = 16'hFF80;

      // R1: reset state
      sample_i = 16'h1234;
      repeat (3) @(negedge clk);
      chk("R1 reset output", data_o, 16'h0000);
      rst_n = 1'b1;

      // R2 R3 R4: stepped sweep over encodings, invert and offsets
      for (int f = 0; f < 4; f++)
         for (int iv = 0; iv < 2; iv++)
            for (int o = 0; o < 6; o++)
               for (int s = 0; s < 65536; s += 3121)
                  step(16'(s), 4'd0, offs[o], iv[0], f[1:0], 1'b0, "R4 R3 encode sweep");
      // R2: limit samples against every offset
      for (int e = 0; e < 6; e++)
         for (int o = 0; o < 256; o++)
            step(edges[e], 4'd0, 8'(o), 1'b0, 2'd0, 1'b0, "R2 saturating offset");
      // R5: disable overrides everything
      for (int s = 0; s < 8; s++)
         step(16'(s * 8191), 4'(s), 8'h10, s[0], s[1:0], 1'b1, "R5 disable idle");
      // R6: static test words and passthrough codes
      for (int f = 0; f < 3; f++) begin
         step(16'h1357, 4'd1, 8'd0, 1'b0, f[1:0], 1'b0, "R6 midscale");
         step(16'h1357, 4'd2, 8'd0, 1'b0, f[1:0], 1'b0, "R6 positive full scale");
         step(16'h1357, 4'd3, 8'd0, 1'b0, f[1:0], 1'b0, "R6 negative full scale");
      end
      for (int m = 8; m < 16; m++)
         step(16'(m * 4099), 4'(m), 8'd0, 1'b0, 2'd0, 1'b0, "R6 upper codes pass data");
      // R11: test words through offset, invert and format
      step(16'h0, 4'd2, 8'hFF, 1'b0, 2'd0, 1'b0, "R11 posfs minus one");
      step(16'h0, 4'd3, 8'h05, 1'b0, 2'd0, 1'b0, "R11 negfs plus five");
      step(16'h0, 4'd1, 8'd0, 1'b1, 2'd0, 1'b0, "R11 midscale inverted");
      step(16'h0, 4'd1, 8'h80, 1'b0, 2'd2, 1'b0, "R11 midscale gray with offset");
      flush();

      alt_check(4'd4, 16'h5555, 16'hAAAA, "R7 checkerboard");
      alt_check(4'd7, 16'hFFFF, 16'h0000, "R8 ones/zeros toggle");
      pn_check(4'd6, 9, 5, 1'b0, "R9 short sequence");
      pn_check(4'd5, 23, 18, 1'b1, "R10 long sequence");

      summary();
      $finish;
   end

endmodule